// File: doc/BRIEF.md
# Lockable Set-Associative Branch Target Buffer

This block predicts branches for a 32-bit instruction fetch path. Each cycle it looks up the fetch address in a set-associative buffer of branch records. One cycle later it reports whether a record was found, whether the branch is predicted taken, and the stored target address. Each record holds a tag, a target and a 2-bit saturating history counter. No static or opcode-hint prediction is applied, so a lookup that finds no record predicts not-taken.

The branch unit reports each resolved branch on a resolve port. A branch that matches a record updates its counter and refreshes its target. A taken branch with no record is allocated into its set. A not-taken branch with no record is dropped. Replacement prefers a free way and otherwise follows a per-set tree pseudo-LRU order that steps around locked ways.

Software controls can do four things: pin a record against eviction, clear every pin, invalidate all unpinned records in one cycle, and switch prediction off. With prediction off, every lookup reports not-taken.

Top module: `branch_target_buffer`

## Requirements
- R1: A lookup is registered. The hit, taken and target outputs in cycle n+1 describe the fetch address applied in cycle n. The set index is address bits [IDX_W+1:2] and the tag is the bits above them. A valid record with a matching tag is a hit, and its stored target is reported.
- R2: A lookup that finds no valid matching record reports hit 0, taken 0 and target 0.
- R3: Each record carries a 2-bit history counter. Values 2 and 3 predict taken, and values 0 and 1 predict not-taken. The counter saturates at 0 and at 3, and a newly allocated record starts at 2.
- R4: A resolve that hits an existing record increments its counter when the branch was taken and decrements it when not taken. The same resolve replaces the stored target with the reported one.
- R5: A not-taken resolve that misses allocates nothing. A taken resolve that misses allocates a record. It uses the lowest-numbered invalid unlocked way if there is one. Otherwise it uses the tree pseudo-LRU victim, where each resolve that hits or allocates marks its way most recently used.
- R6: A lock request whose address hits a valid record sets that record's lock bit. A locked record is never chosen for replacement. If every way of the set is locked, a taken miss is not allocated.
- R7: A flush clears the valid bit of every unlocked record in one cycle. Locked records keep hitting afterwards.
- R8: Unlock-all clears every lock bit. When unlock-all and flush are asserted in the same cycle, the unlock takes effect first, so every record is invalidated.
- R9: While the prediction enable input is low, taken is 0 on the following cycle's output, while hit and target are still reported.
- R10: A resolve in the same cycle as a lookup of the same address is not seen by that lookup. It is seen by lookups from the next cycle onward.
- R11: After reset, every record is invalid and unlocked, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_en_i | input | 1 | Dynamic prediction enable |
| fetch_addr_i | input | ADDR_W | Fetch address to look up |
| hit_o | output | 1 | Registered lookup hit |
| taken_o | output | 1 | Registered taken prediction |
| target_o | output | ADDR_W | Registered predicted target |
| res_valid_i | input | 1 | Resolved branch report valid |
| res_pc_i | input | ADDR_W | Address of the resolved branch |
| res_taken_i | input | 1 | Resolved direction (1 = taken) |
| res_target_i | input | ADDR_W | Resolved target |
| lock_i | input | 1 | Lock request |
| lock_pc_i | input | ADDR_W | Address whose record is to be locked |
| flush_i | input | 1 | Invalidate all unlocked records |
| unlock_all_i | input | 1 | Clear all lock bits |

## Verification
The bench builds the block with SETS=4 and WAYS=4, so the index is address bits [3:2]. With these values a handful of branches fills a set. That brings eviction order, lock skipping and the all-ways-locked case within reach in a few dozen cycles. The counter walk exercises both saturation ends, using sequences whose outcome differs from a wrapping counter. The same-cycle resolve and lookup case, and the flush and unlock-all combination, are driven directly at the ports.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_ALLOC = 2'd2;

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken)
            return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic ctr_predicts(input ctr_t c);
        return c[1];
    endfunction
endpackage

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            way_o
);
    logic [WAYS-1:0] match;

    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = valid_i[w] && (tags_i[w] == tag_i);
            if (match[w] && !hit_o) begin
                hit_o = 1'b1;
                way_o = WAY_W'(w);
            end
        end
    end

    // R5
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/btb_victim_sel.sv
module btb_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAYS-1:0]   valid_i,
    input  logic [WAYS-1:0]   lock_i,
    input  logic [WAYS-2:0]   tree_i,
    output logic [WAY_W-1:0]  victim_o,
    output logic              none_free_o
);
    int   lo, span, half, node;
    logic left_full, right_full, go_r, free_found;

    always_comb begin
        none_free_o = &lock_i;
        // tree walk that steps around fully locked subtrees
        lo   = 0;
        span = WAYS;
        node = 1;
        go_r = 1'b0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            half       = span / 2;
            left_full  = 1'b1;
            right_full = 1'b1;
            for (int w = 0; w < WAYS; w++) begin
                if (w >= lo && w < lo + half)        left_full  = left_full  & lock_i[w];
                if (w >= lo + half && w < lo + span) right_full = right_full & lock_i[w];
            end
            go_r = tree_i[node-1];
            if (go_r && right_full)       go_r = 1'b0;
            else if (!go_r && left_full)  go_r = 1'b1;
            if (go_r) lo = lo + half;
            node = 2 * node + (go_r ? 1 : 0);
            span = half;
        end
        victim_o   = WAY_W'(lo);
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_i[w] && !lock_i[w] && !free_found) begin
                free_found = 1'b1;
                victim_o   = WAY_W'(w);
            end
        end
    end

    // R6
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !none_free_o |-> !lock_i[victim_o]);
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 128,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_en_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              hit_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    input  logic              res_valid_i,
    input  logic [ADDR_W-1:0] res_pc_i,
    input  logic              res_taken_i,
    input  logic [ADDR_W-1:0] res_target_i,
    input  logic              lock_i,
    input  logic [ADDR_W-1:0] lock_pc_i,
    input  logic              flush_i,
    input  logic              unlock_all_i
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    typedef struct packed {
        logic              valid;
        logic              lock;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
        ctr_t              ctr;
    } entry_t;

    typedef struct {
        entry_t            ent  [SETS][WAYS];
        logic [WAYS-2:0]   tree [SETS];
        logic              hit;
        logic              taken;
        logic [ADDR_W-1:0] tgt;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [WAYS-2:0] plru_touch(input logic [WAYS-2:0] t,
                                                   input logic [WAY_W-1:0] w);
        int node;
        logic b;
        node = 1;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            b         = w[WAY_W-1-lvl];
            t[node-1] = ~b;
            node      = 2 * node + (b ? 1 : 0);
        end
        return t;
    endfunction

    // address split
    logic [IDX_W-1:0] f_idx, r_idx, l_idx;
    logic [TAG_W-1:0] f_tag, r_tag, l_tag;
    assign f_idx = fetch_addr_i[IDX_W+1:2];
    assign f_tag = fetch_addr_i[ADDR_W-1:IDX_W+2];
    assign r_idx = res_pc_i[IDX_W+1:2];
    assign r_tag = res_pc_i[ADDR_W-1:IDX_W+2];
    assign l_idx = lock_pc_i[IDX_W+1:2];
    assign l_tag = lock_pc_i[ADDR_W-1:IDX_W+2];

    logic [WAYS-1:0]            f_valid, r_valid, l_valid, r_lock;
    logic [WAYS-1:0][TAG_W-1:0] f_tags, r_tags, l_tags;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            f_valid[w] = st_q.ent[f_idx][w].valid;
            f_tags[w]  = st_q.ent[f_idx][w].tag;
            r_valid[w] = st_q.ent[r_idx][w].valid;
            r_lock[w]  = st_q.ent[r_idx][w].lock;
            r_tags[w]  = st_q.ent[r_idx][w].tag;
            l_valid[w] = st_q.ent[l_idx][w].valid;
            l_tags[w]  = st_q.ent[l_idx][w].tag;
        end
    end

    logic             f_hit, r_hit, l_hit, v_none;
    logic [WAY_W-1:0] f_way, r_way, l_way, v_way;

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_fetch_match (
        .clk(clk), .rst_n(rst_n), .valid_i(f_valid), .tags_i(f_tags),
        .tag_i(f_tag), .hit_o(f_hit), .way_o(f_way));

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_res_match (
        .clk(clk), .rst_n(rst_n), .valid_i(r_valid), .tags_i(r_tags),
        .tag_i(r_tag), .hit_o(r_hit), .way_o(r_way));

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lock_match (
        .clk(clk), .rst_n(rst_n), .valid_i(l_valid), .tags_i(l_tags),
        .tag_i(l_tag), .hit_o(l_hit), .way_o(l_way));

    btb_victim_sel #(.WAYS(WAYS)) i_victim (
        .clk(clk), .rst_n(rst_n), .valid_i(r_valid), .lock_i(r_lock),
        .tree_i(st_q.tree[r_idx]), .victim_o(v_way), .none_free_o(v_none));

    always_comb begin
        st_d = st_q;
        // lookup reads the registered state only
        st_d.hit   = f_hit;
        st_d.taken = f_hit && pred_en_i && ctr_predicts(st_q.ent[f_idx][f_way].ctr);
        st_d.tgt   = f_hit ? st_q.ent[f_idx][f_way].tgt : '0;
        // resolve: update or allocate
        if (res_valid_i) begin
            if (r_hit) begin
                st_d.ent[r_idx][r_way].ctr = ctr_step(st_q.ent[r_idx][r_way].ctr, res_taken_i);
                st_d.ent[r_idx][r_way].tgt = res_target_i;
                st_d.tree[r_idx]           = plru_touch(st_q.tree[r_idx], r_way);
            end else if (res_taken_i && !v_none) begin
                st_d.ent[r_idx][v_way] = '{valid: 1'b1, lock: 1'b0, tag: r_tag,
                                           tgt: res_target_i, ctr: CTR_ALLOC};
                st_d.tree[r_idx]       = plru_touch(st_q.tree[r_idx], v_way);
            end
        end
        // lock a record that is still present after this cycle's resolve
        if (lock_i && l_hit && st_d.ent[l_idx][l_way].valid
                && st_d.ent[l_idx][l_way].tag == l_tag)
            st_d.ent[l_idx][l_way].lock = 1'b1;
        // unlock before flush
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (unlock_all_i) st_d.ent[s][w].lock = 1'b0;
                if (flush_i && !st_d.ent[s][w].lock) st_d.ent[s][w].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                st_q.tree[s] <= '0;
                for (int w = 0; w < WAYS; w++) st_q.ent[s][w] <= '0;
            end
            st_q.hit   <= 1'b0;
            st_q.taken <= 1'b0;
            st_q.tgt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o    = st_q.hit;
    assign taken_o  = st_q.taken;
    assign target_o = st_q.tgt;

    // state summaries used by the checks below
    logic unlocked_valid_any, any_lock;
    always_comb begin
        unlocked_valid_any = 1'b0;
        any_lock           = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st_q.ent[s][w].valid && !st_q.ent[s][w].lock) unlocked_valid_any = 1'b1;
                if (st_q.ent[s][w].lock) any_lock = 1'b1;
            end
        end
    end

    // R9
    pred_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pred_en_i) |-> !taken_o);
    // R2
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (!taken_o && target_o == '0));
    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !unlocked_valid_any);
    // R8
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_all_i |=> !any_lock);
endmodule

// File: tb/test_branch_target_buffer.sv
module test_branch_target_buffer;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_en = 1'b1;
    logic [AW-1:0] fetch_addr = '0;
    logic          hit, taken;
    logic [AW-1:0] target;
    logic          res_valid = 1'b0, res_taken = 1'b0;
    logic [AW-1:0] res_pc = '0, res_target = '0;
    logic          lock = 1'b0, flush = 1'b0, unlock_all = 1'b0;
    logic [AW-1:0] lock_pc = '0;

    always #4 clk = ~clk;

    branch_target_buffer #(.ADDR_W(AW), .SETS(4), .WAYS(4)) i_branch_target_buffer (
        .clk(clk), .rst_n(rst_n), .pred_en_i(pred_en), .fetch_addr_i(fetch_addr),
        .hit_o(hit), .taken_o(taken), .target_o(target),
        .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
        .res_target_i(res_target), .lock_i(lock), .lock_pc_i(lock_pc),
        .flush_i(flush), .unlock_all_i(unlock_all));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // index = addr[3:2], tag = addr[31:4]
    localparam logic [31:0] PA  = 32'h10;
    localparam logic [31:0] PB0 = 32'h14, PB1 = 32'h24, PB2 = 32'h34, PB3 = 32'h44;
    localparam logic [31:0] PB4 = 32'h54, PB5 = 32'h64, PB6 = 32'h74, PB7 = 32'h84;
    localparam logic [31:0] PC  = 32'h18;

    localparam logic [1:0] LK = 2'd0, RS = 2'd1, LO = 2'd2, BO = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] pc;
        logic        tk;
        logic [31:0] tgt;
        logic        eh;
        logic        et;
        logic [31:0] etg;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VEC [NV] = '{
        '{LK, PA,  1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 0  R2 empty
        '{RS, PA,  1'b0, 32'h1000, 1'b0, 1'b0, 32'h0},    // 1  nt miss
        '{LK, PA,  1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 2  R5 no alloc
        '{RS, PA,  1'b1, 32'h1000, 1'b0, 1'b0, 32'h0},    // 3  alloc ctr 2
        '{LK, PA,  1'b0, 32'h0,    1'b1, 1'b1, 32'h1000}, // 4  R3 start at 2
        '{RS, PA,  1'b0, 32'h1000, 1'b0, 1'b0, 32'h0},    // 5  ctr 1
        '{LK, PA,  1'b0, 32'h0,    1'b1, 1'b0, 32'h1000}, // 6  R4 decrement
        '{RS, PA,  1'b0, 32'h1000, 1'b0, 1'b0, 32'h0},    // 7  ctr 0
        '{RS, PA,  1'b0, 32'h1000, 1'b0, 1'b0, 32'h0},    // 8  stays 0
        '{RS, PA,  1'b1, 32'h2000, 1'b0, 1'b0, 32'h0},    // 9  ctr 1
        '{RS, PA,  1'b1, 32'h2000, 1'b0, 1'b0, 32'h0},    // 10 ctr 2
        '{LK, PA,  1'b0, 32'h0,    1'b1, 1'b1, 32'h2000}, // 11 R3 low saturation
        '{RS, PA,  1'b1, 32'h2000, 1'b0, 1'b0, 32'h0},    // 12 ctr 3
        '{RS, PA,  1'b1, 32'h2000, 1'b0, 1'b0, 32'h0},    // 13 stays 3
        '{RS, PA,  1'b1, 32'h2000, 1'b0, 1'b0, 32'h0},    // 14 stays 3
        '{RS, PA,  1'b0, 32'h2000, 1'b0, 1'b0, 32'h0},    // 15 ctr 2
        '{RS, PA,  1'b0, 32'h2000, 1'b0, 1'b0, 32'h0},    // 16 ctr 1
        '{LK, PA,  1'b0, 32'h0,    1'b1, 1'b0, 32'h2000}, // 17 R3 high saturation
        '{RS, PB0, 1'b1, 32'h100,  1'b0, 1'b0, 32'h0},    // 18 way0
        '{RS, PB1, 1'b1, 32'h200,  1'b0, 1'b0, 32'h0},    // 19 way1
        '{RS, PB2, 1'b1, 32'h300,  1'b0, 1'b0, 32'h0},    // 20 way2
        '{RS, PB3, 1'b1, 32'h400,  1'b0, 1'b0, 32'h0},    // 21 way3
        '{LK, PB0, 1'b0, 32'h0,    1'b1, 1'b1, 32'h100},  // 22 R1
        '{LK, PB3, 1'b0, 32'h0,    1'b1, 1'b1, 32'h400},  // 23 R1
        '{RS, PB4, 1'b1, 32'h500,  1'b0, 1'b0, 32'h0},    // 24 evicts way0
        '{LK, PB0, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 25 R5 oldest gone
        '{LK, PB1, 1'b0, 32'h0,    1'b1, 1'b1, 32'h200},  // 26 R5
        '{LO, PB1, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 27 lock way1
        '{RS, PB5, 1'b1, 32'h600,  1'b0, 1'b0, 32'h0},    // 28 evicts way2
        '{LK, PB2, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 29 R5
        '{LK, PB1, 1'b0, 32'h0,    1'b1, 1'b1, 32'h200},  // 30 R6 locked kept
        '{RS, PB6, 1'b1, 32'h700,  1'b0, 1'b0, 32'h0},    // 31 skips way1 -> way0
        '{LK, PB4, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 32 R6
        '{LK, PB6, 1'b0, 32'h0,    1'b1, 1'b1, 32'h700},  // 33 R6
        '{LO, PB3, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 34
        '{LO, PB5, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 35
        '{LO, PB6, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 36 all locked
        '{RS, PB7, 1'b1, 32'h800,  1'b0, 1'b0, 32'h0},    // 37 dropped
        '{LK, PB7, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},    // 38 R6 no alloc
        '{LK, PB3, 1'b0, 32'h0,    1'b1, 1'b1, 32'h400},  // 39 R6
        '{LK, PB5, 1'b0, 32'h0,    1'b1, 1'b1, 32'h600},  // 40 R6
        '{BO, PC,  1'b1, 32'h900,  1'b0, 1'b0, 32'h0},    // 41 R10 same cycle
        '{LK, PC,  1'b0, 32'h0,    1'b1, 1'b1, 32'h900}   // 42 R10 next cycle
    };

    task automatic check(input string req, input logic eh, input logic et,
                         input logic [AW-1:0] etg);
        n_checks++;
        if (hit !== eh || taken !== et || target !== etg) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b taken=%0b target=%h, expected hit=%0b taken=%0b target=%h",
                     req, hit, taken, target, eh, et, etg);
        end
    endtask

    task automatic look(input logic [AW-1:0] pc, input string req, input logic eh,
                        input logic et, input logic [AW-1:0] etg);
        fetch_addr = pc;
        @(negedge clk);
        check(req, eh, et, etg);
    endtask

    task automatic resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tg);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tg;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic pulse_ctl(input logic do_flush, input logic do_unlock);
        flush = do_flush; unlock_all = do_unlock;
        @(negedge clk);
        flush = 1'b0; unlock_all = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        n_checks++;
        if (hit !== 1'b0 || taken !== 1'b0 || target !== '0) begin
            n_fail++;
            $display("FAIL R11: got hit=%0b taken=%0b target=%h, expected 0 0 0", hit, taken, target);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                LK: look(VEC[i].pc, $sformatf("R1/R3 vec %0d", i), VEC[i].eh, VEC[i].et, VEC[i].etg);
                RS: resolve(VEC[i].pc, VEC[i].tk, VEC[i].tgt);
                LO: begin
                    lock = 1'b1; lock_pc = VEC[i].pc;
                    @(negedge clk);
                    lock = 1'b0;
                end
                default: begin
                    res_valid = 1'b1; res_pc = VEC[i].pc; res_taken = VEC[i].tk;
                    res_target = VEC[i].tgt; fetch_addr = VEC[i].pc;
                    @(negedge clk);
                    res_valid = 1'b0;
                    check($sformatf("R10 vec %0d", i), VEC[i].eh, VEC[i].et, VEC[i].etg);
                end
            endcase
        end
        // R7 flush keeps locked records only
        pulse_ctl(1'b1, 1'b0);
        look(PA,  "R7 unlocked flushed", 1'b0, 1'b0, 32'h0);
        look(PB1, "R7 locked survives",  1'b1, 1'b1, 32'h200);
        look(PC,  "R7 unlocked flushed", 1'b0, 1'b0, 32'h0);
        // R8 unlock-all alone frees the set for allocation
        pulse_ctl(1'b0, 1'b1);
        resolve(PB7, 1'b1, 32'h800);
        look(PB7, "R8 allocation after unlock", 1'b1, 1'b1, 32'h800);
        // R8 unlock and flush together clear everything
        pulse_ctl(1'b1, 1'b1);
        look(PB1, "R8 unlock before flush", 1'b0, 1'b0, 32'h0);
        look(PB7, "R8 unlock before flush", 1'b0, 1'b0, 32'h0);
        // R9 prediction disable
        resolve(PA, 1'b1, 32'hA00);
        pred_en = 1'b0;
        look(PA, "R9 disabled", 1'b1, 1'b0, 32'hA00);
        pred_en = 1'b1;
        look(PA, "R9 re-enabled", 1'b1, 1'b1, 32'hA00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion within 5000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule